// File: doc/BRIEF.md
# LPC TPM-Cycle Target Interface

This block sits on the target side of a Low Pin Count bus and runs on the bus clock. It watches the 4-bit multiplexed address/data lines together with the active-low framing strobe. It services only TPM-type single-byte reads and writes. Every other kind of bus cycle passes without any reply. For a serviced cycle the block gathers the 16-bit address and, for a write, the data byte. It then presents a read or write request to an internal register port. While the port is still busy it answers with long-wait SYNC codes. When the request completes it sends SYNC OK, returns the read byte if there is one, and performs the target turnaround.

The register side can refuse an access in the first clock of a request. The block then stays silent for the whole cycle, which the host sees as a master abort. A cycle never ends with an error SYNC. If the register side stays busy for longer than a parameterised number of wait clocks, the block withdraws the request and still closes the cycle with SYNC OK. Whenever the framing strobe is asserted, any cycle in progress ends at once.

Top module: `lpc_tpm_target`

## Requirements
- R1: A cycle is serviced only when the framing strobe is low with START nibble 0101 on the bus and the next nibble is 0000 (read) or 0010 (write). Any other START value, and any other direction nibble after 0101, produces no LAD drive and no register request.
- R2: The 16-bit address arrives most-significant nibble first, in the four clocks after the direction nibble. Write data follows low nibble first. The register port presents exactly that address and byte, with `reg_wr` for writes and `reg_rd` for reads, never both.
- R3: The request starts in the second host turnaround clock. During that clock LAD is not driven. The request is then held until `reg_ready`, and the block drives long-wait 0110 in every clock after the first request clock in which the request is still pending.
- R4: After the request completes, the block drives 0000 (SYNC OK) for one clock. A read then returns the low data nibble, followed by the high data nibble. The block then drives 1111 for one clock and releases LAD in the next clock.
- R5: If `reg_ready` has not arrived after WAIT_MAX long-wait clocks, the request is withdrawn without a write and SYNC OK follows. A read then returns 0xFF.
- R6: When `reg_reject` is high in the first request clock, the cycle ends with LAD never driven and no register write. `reg_reject` is ignored in later request clocks.
- R7: The only codes driven during the SYNC phase are 0110 and 0000. The error code is never produced.
- R8: A clock with the framing strobe low ends any cycle in progress and withdraws a pending request. If that clock also carries START 0101, a new cycle begins.
- R9: While `rst_n` is low at a clock edge, the block returns to idle with LAD released and no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low cycle framing strobe |
| lad_in | input | 4 | Address/data nibble seen on the bus |
| lad_out | output | 4 | Nibble the block drives onto the bus |
| lad_oe | output | 1 | Drive enable for `lad_out` |
| reg_addr | output | 16 | Register address of the current cycle |
| reg_wdata | output | 8 | Write byte of the current cycle |
| reg_rd | output | 1 | Read request, held until answered |
| reg_wr | output | 1 | Write request, held until answered |
| reg_rdata | input | 8 | Read byte from the register side |
| reg_ready | input | 1 | Register side completes the request this clock |
| reg_reject | input | 1 | Register side refuses the request (first request clock) |

## Verification
The bench builds the block with WAIT_MAX = 4. At that value the full range of register-side latencies, from zero up to one clock past the limit, can be swept in a few dozen cycles. Those runs cover zero to four long-wait codes and the timeout that answers 0xFF or drops the write. The register model holds 16 bytes, indexed by the low address nibble. Every location can therefore be written and read back with computed data, and a refused write to an aliased address shows up as an unchanged byte. The bench sweeps all fifteen foreign START values and all fourteen foreign direction nibbles, and it exercises strobe aborts both during the header and during the wait phase.

// File: rtl/lpc_tpm_pkg.sv
// Shared encodings and types for the LPC TPM-cycle target.
// Assumes single-byte TPM cycles with a 16-bit address.
package lpc_tpm_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int ADDR_NIBS = ADDR_W / 4;
    localparam int DATA_NIBS = DATA_W / 4;
    localparam int NIB_CW    = 2;

    localparam logic [3:0] NIB_TPM_START = 4'b0101;
    localparam logic [3:0] NIB_DIR_READ  = 4'b0000;
    localparam logic [3:0] NIB_DIR_WRITE = 4'b0010;
    localparam logic [3:0] NIB_SYNC_OK   = 4'b0000;
    localparam logic [3:0] NIB_SYNC_WAIT = 4'b0110;
    localparam logic [3:0] NIB_PARK      = 4'b1111;
    localparam logic [DATA_W-1:0] DATA_TIMEOUT = '1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_WDATA,
        ST_HTAR,
        ST_SYNC_WAIT,
        ST_SYNC_OK,
        ST_RDATA,
        ST_TTAR
    } lpc_state_e;
endpackage

// File: rtl/lpc_tpm_fsm.sv
// Cycle sequencer: walks header, turnaround, sync and tail phases.
// Assumes reg_reject is a decode valid in the first request clock;
// a low frame_n always overrides the current phase.
module lpc_tpm_fsm
    import lpc_tpm_pkg::*;
#(
    parameter int WAIT_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        lad_in,
    input  logic              reg_ready,
    input  logic              reg_reject,
    output lpc_state_e        state,
    output logic [NIB_CW-1:0] nib_idx,
    output logic              is_write,
    output logic              req,
    output logic              take_rdata,
    output logic              take_timeout
);
    localparam int WCW = $clog2(WAIT_MAX + 1);
    localparam logic [WCW-1:0] WCNT_LAST = WCW'(WAIT_MAX - 1);
    localparam logic [NIB_CW-1:0] ADDR_LAST = NIB_CW'(ADDR_NIBS - 1);
    localparam logic [NIB_CW-1:0] DATA_LAST = NIB_CW'(DATA_NIBS - 1);

    lpc_state_e        state_q, state_d;
    logic [NIB_CW-1:0] nib_q, nib_d;
    logic              wr_q, wr_d;
    logic [WCW-1:0]    wcnt_q, wcnt_d;
    logic              first_req, last_wait;

    // Request window: second host turnaround clock plus every wait clock.
    always_comb begin
        first_req    = (state_q == ST_HTAR) && (nib_q == NIB_CW'(1));
        last_wait    = (state_q == ST_SYNC_WAIT) && (wcnt_q == WCNT_LAST);
        req          = frame_n && (first_req || state_q == ST_SYNC_WAIT);
        take_rdata   = req && !wr_q && reg_ready && !(first_req && reg_reject);
        take_timeout = req && !reg_ready && last_wait;
    end

    // Next-phase decision for each clock.
    always_comb begin
        state_d = state_q;
        nib_d   = nib_q;
        wr_d    = wr_q;
        wcnt_d  = wcnt_q;
        if (!frame_n) begin
            state_d = (lad_in == NIB_TPM_START) ? ST_CTYPE : ST_IDLE;
            nib_d   = '0;
        end else begin
            case (state_q)
                ST_CTYPE: begin
                    nib_d = '0;
                    if (lad_in == NIB_DIR_READ) begin
                        wr_d = 1'b0; state_d = ST_ADDR;
                    end else if (lad_in == NIB_DIR_WRITE) begin
                        wr_d = 1'b1; state_d = ST_ADDR;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    if (nib_q == ADDR_LAST) begin
                        nib_d   = '0;
                        state_d = wr_q ? ST_WDATA : ST_HTAR;
                    end else begin
                        nib_d = nib_q + NIB_CW'(1);
                    end
                end
                ST_WDATA: begin
                    if (nib_q == DATA_LAST) begin
                        nib_d = '0; state_d = ST_HTAR;
                    end else begin
                        nib_d = nib_q + NIB_CW'(1);
                    end
                end
                ST_HTAR: begin
                    if (nib_q == '0) begin
                        nib_d = NIB_CW'(1);
                    end else begin
                        nib_d  = '0;
                        wcnt_d = '0;
                        if (reg_reject)     state_d = ST_IDLE;
                        else if (reg_ready) state_d = ST_SYNC_OK;
                        else                state_d = ST_SYNC_WAIT;
                    end
                end
                ST_SYNC_WAIT: begin
                    if (reg_ready || last_wait) state_d = ST_SYNC_OK;
                    else                        wcnt_d  = wcnt_q + WCW'(1);
                end
                ST_SYNC_OK: begin
                    nib_d   = '0;
                    state_d = wr_q ? ST_TTAR : ST_RDATA;
                end
                ST_RDATA: begin
                    if (nib_q == DATA_LAST) begin
                        nib_d = '0; state_d = ST_TTAR;
                    end else begin
                        nib_d = nib_q + NIB_CW'(1);
                    end
                end
                ST_TTAR: begin
                    if (nib_q == '0) nib_d = NIB_CW'(1);
                    else begin nib_d = '0; state_d = ST_IDLE; end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Phase registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            nib_q   <= '0;
            wr_q    <= 1'b0;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            nib_q   <= nib_d;
            wr_q    <= wr_d;
            wcnt_q  <= wcnt_d;
        end
    end

    assign state    = state_q;
    assign nib_idx  = nib_q;
    assign is_write = wr_q;

    a_r1_foreign_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CTYPE && frame_n && lad_in != NIB_DIR_READ && lad_in != NIB_DIR_WRITE)
        |=> state_q == ST_IDLE);
    a_r8_frame_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && lad_in != NIB_TPM_START) |=> state_q == ST_IDLE);
    a_r8_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && lad_in == NIB_TPM_START) |=> state_q == ST_CTYPE);
    a_r5_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC_WAIT) |-> (wcnt_q < WCW'(WAIT_MAX)));
endmodule

// File: rtl/lpc_tpm_capture.sv
// Holds the cycle address, the write byte and the byte to return.
// Assumes the sequencer phase and nibble index arrive from lpc_tpm_fsm.
module lpc_tpm_capture
    import lpc_tpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        lad_in,
    input  lpc_state_e        state,
    input  logic [NIB_CW-1:0] nib_idx,
    input  logic              take_rdata,
    input  logic              take_timeout,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    // Address shifts in most-significant nibble first.
    always_ff @(posedge clk) begin
        if (!rst_n)                                addr <= '0;
        else if (frame_n && state == ST_ADDR)      addr <= {addr[ADDR_W-5:0], lad_in};
    end

    // One slot per write-data nibble, low nibble first on the bus.
    for (genvar g = 0; g < DATA_NIBS; g++) begin : g_wnib
        always_ff @(posedge clk) begin
            if (!rst_n)
                wdata[g*4 +: 4] <= '0;
            else if (frame_n && state == ST_WDATA && nib_idx == NIB_CW'(g))
                wdata[g*4 +: 4] <= lad_in;
        end
    end

    // Return byte: register answer, or all ones on wait timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)            rdata <= '0;
        else if (take_rdata)   rdata <= reg_rdata;
        else if (take_timeout) rdata <= DATA_TIMEOUT;
    end
endmodule

// File: rtl/lpc_tpm_lad_drive.sv
// Decodes the current phase into the LAD drive value and enable.
// Assumes a registered phase so nothing on LAD depends on register inputs.
module lpc_tpm_lad_drive
    import lpc_tpm_pkg::*;
(
    input  lpc_state_e        state,
    input  logic [NIB_CW-1:0] nib_idx,
    input  logic [DATA_W-1:0] rdata,
    output logic [3:0]        lad_out,
    output logic              lad_oe
);
    // Drive only in the sync, read-data and first target turnaround clocks.
    always_comb begin
        lad_out = '0;
        lad_oe  = 1'b0;
        case (state)
            ST_SYNC_WAIT: begin lad_oe = 1'b1; lad_out = NIB_SYNC_WAIT; end
            ST_SYNC_OK:   begin lad_oe = 1'b1; lad_out = NIB_SYNC_OK;   end
            ST_RDATA:     begin lad_oe = 1'b1; lad_out = rdata[nib_idx*4 +: 4]; end
            ST_TTAR: begin
                lad_oe  = (nib_idx == '0);
                lad_out = NIB_PARK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpc_tpm_target.sv
// Top of the LPC TPM-cycle target: sequencer, capture and LAD drive.
// Assumes the register side answers reg_ready/reg_reject during a request
// and commits a write only on reg_wr && reg_ready.
module lpc_tpm_target
    import lpc_tpm_pkg::*;
#(
    parameter int WAIT_MAX = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic [3:0]  lad_in,
    output logic [3:0]  lad_out,
    output logic        lad_oe,
    output logic [15:0] reg_addr,
    output logic [7:0]  reg_wdata,
    output logic        reg_rd,
    output logic        reg_wr,
    input  logic [7:0]  reg_rdata,
    input  logic        reg_ready,
    input  logic        reg_reject
);
    lpc_state_e        state;
    logic [NIB_CW-1:0] nib_idx;
    logic              is_write, req, take_rdata, take_timeout;
    logic [DATA_W-1:0] rdata;

    lpc_tpm_fsm #(.WAIT_MAX(WAIT_MAX)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
        .reg_ready(reg_ready), .reg_reject(reg_reject),
        .state(state), .nib_idx(nib_idx), .is_write(is_write), .req(req),
        .take_rdata(take_rdata), .take_timeout(take_timeout)
    );

    lpc_tpm_capture u_cap (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
        .state(state), .nib_idx(nib_idx),
        .take_rdata(take_rdata), .take_timeout(take_timeout),
        .reg_rdata(reg_rdata),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(rdata)
    );

    lpc_tpm_lad_drive u_drv (
        .state(state), .nib_idx(nib_idx), .rdata(rdata),
        .lad_out(lad_out), .lad_oe(lad_oe)
    );

    // Split the request by direction.
    always_comb begin
        reg_rd = req && !is_write;
        reg_wr = req && is_write;
    end

    a_r2_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rd, reg_wr}));
    a_r7_pending_code: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rd || reg_wr) && lad_oe) |-> lad_out == NIB_SYNC_WAIT);
    a_r6_silent_abort: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rd || reg_wr) && !lad_oe && reg_reject)
        |=> (!lad_oe && !reg_rd && !reg_wr));
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!lad_oe && !reg_rd && !reg_wr));
endmodule

// File: tb/lpc_tpm_target_tb.sv
`timescale 1ns/1ps
module lpc_tpm_target_tb;
    localparam int WAIT_MAX = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1;
    logic [3:0] lad_in = 4'hF;
    logic [3:0] lad_out;
    logic       lad_oe;
    logic [15:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       reg_rd, reg_wr, reg_ready, reg_reject;

    lpc_tpm_target #(.WAIT_MAX(WAIT_MAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_rdata(reg_rdata), .reg_ready(reg_ready), .reg_reject(reg_reject)
    );

    // Register-side model: 16 bytes, refuses addresses 0xFxxx, latency cur_lat.
    logic [7:0] mem [16];
    int cur_lat = 0;
    int req_run = 0;
    int req_clks = 0;
    int commits = 0;
    logic [15:0] last_waddr = '0, last_raddr = '0;
    logic [7:0]  last_wdata = '0;
    wire req_any = reg_rd | reg_wr;
    assign reg_reject = req_any && (reg_addr[15:12] == 4'hF);
    assign reg_ready  = req_any && !reg_reject && (req_run >= cur_lat);
    assign reg_rdata  = mem[reg_addr[3:0]];

    initial for (int i = 0; i < 16; i++) mem[i] = 8'h00;

    always @(posedge clk) begin
        req_run <= req_any ? req_run + 1 : 0;
        if (req_any) req_clks <= req_clks + 1;
        if (reg_rd) last_raddr <= reg_addr;
        if (reg_wr && reg_ready) begin
            mem[reg_addr[3:0]] <= reg_wdata;
            last_waddr <= reg_addr;
            last_wdata <= reg_wdata;
            commits    <= commits + 1;
        end
    end

    int n_tests = 0, n_fail = 0;
    logic [7:0] expm [16];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Observe the block's drive for the current clock, then set the next host inputs.
    task automatic cyc(input logic f, input logic [3:0] d,
                       output logic oe, output logic [3:0] o);
        @(negedge clk);
        oe = lad_oe; o = lad_out;
        frame_n = f; lad_in = d;
    endtask

    task automatic tpm_xfer(input bit wr, input logic [15:0] a, input logic [7:0] d,
                            input int lat, output int nwait, output bit synced,
                            output bit bad_code, output logic [7:0] rd,
                            output bit tail_ok, output bit early);
        logic oe; logic [3:0] o; bit t1, t2;
        cur_lat = lat; nwait = 0; synced = 0; bad_code = 0; rd = 8'h00;
        tail_ok = 0; early = 0; t2 = 1;
        cyc(1'b0, 4'h5, oe, o); early |= oe;
        cyc(1'b1, wr ? 4'h2 : 4'h0, oe, o); early |= oe;
        for (int i = 3; i >= 0; i--) begin cyc(1'b1, a[i*4 +: 4], oe, o); early |= oe; end
        if (wr) begin
            cyc(1'b1, d[3:0], oe, o); early |= oe;
            cyc(1'b1, d[7:4], oe, o); early |= oe;
        end
        cyc(1'b1, 4'hF, oe, o); early |= oe;
        cyc(1'b1, 4'hF, oe, o); early |= oe;
        for (int k = 0; k < 40; k++) begin
            cyc(1'b1, 4'hF, oe, o);
            if (!oe) break;
            if (o == 4'h6) nwait++;
            else if (o == 4'h0) begin synced = 1; break; end
            else begin bad_code = 1; break; end
        end
        if (synced) begin
            if (!wr) begin
                cyc(1'b1, 4'hF, oe, o); rd[3:0] = o; t2 &= oe;
                cyc(1'b1, 4'hF, oe, o); rd[7:4] = o; t2 &= oe;
            end
            cyc(1'b1, 4'hF, oe, o); t1 = oe && (o == 4'hF);
            cyc(1'b1, 4'hF, oe, o);
            tail_ok = t1 && t2 && !oe;
        end
    endtask

    // Foreign cycle: any drive or request during it or just after counts as a response.
    task automatic foreign(input logic [3:0] s, input logic [3:0] c, output bit drove);
        logic oe; logic [3:0] o; int r0;
        r0 = req_clks; drove = 0;
        cyc(1'b0, s, oe, o); drove |= oe;
        cyc(1'b1, c, oe, o); drove |= oe;
        for (int i = 0; i < 6; i++) begin cyc(1'b1, 4'h1, oe, o); drove |= oe; end
        for (int i = 0; i < 10; i++) begin cyc(1'b1, 4'hF, oe, o); drove |= oe; end
        if (req_clks != r0) drove = 1;
    endtask

    int nw; bit sy, bad, tail, early, drove; logic [7:0] rd;
    logic oe_s; logic [3:0] o_s;

    initial begin
        for (int i = 0; i < 16; i++) expm[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R9: idle state right after reset
        chk(!lad_oe && !reg_rd && !reg_wr, "R9", "reset idle", int'(lad_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R7: write every location with latencies 0..4
        for (int a = 0; a < 16; a++) begin
            logic [15:0] ad; logic [7:0] dv;
            ad = {4'(a % 8), 4'(a), 4'(15 - a), 4'(a)};
            dv = 8'(a * 29 + 7);
            tpm_xfer(1'b1, ad, dv, a % 5, nw, sy, bad, rd, tail, early);
            expm[a] = dv;
            chk(sy && !bad && !early, "R7", "write sync ok", int'(sy), 1);
            chk(nw == a % 5, "R3", "write long waits", nw, a % 5);
            chk(tail, "R4", "write turnaround", int'(tail), 1);
            chk(last_waddr == ad, "R2", "write address", int'(last_waddr), int'(ad));
            chk(last_wdata == dv, "R2", "write data", int'(last_wdata), int'(dv));
        end

        // R2 R3 R4: read back with other latencies
        for (int a = 0; a < 16; a++) begin
            logic [15:0] ad;
            ad = {4'(a % 8), 4'(15 - a), 4'(a), 4'(a)};
            tpm_xfer(1'b0, ad, 8'h00, (a * 3) % 5, nw, sy, bad, rd, tail, early);
            chk(sy && !bad && !early, "R7", "read sync ok", int'(sy), 1);
            chk(nw == (a * 3) % 5, "R3", "read long waits", nw, (a * 3) % 5);
            chk(rd == expm[a], "R4", "read data", int'(rd), int'(expm[a]));
            chk(tail, "R4", "read turnaround", int'(tail), 1);
            chk(last_raddr == ad, "R2", "read address", int'(last_raddr), int'(ad));
        end

        // R5: timeout on read and on write
        tpm_xfer(1'b0, 16'h0003, 8'h00, WAIT_MAX + 1, nw, sy, bad, rd, tail, early);
        chk(sy && nw == WAIT_MAX, "R5", "read timeout waits", nw, WAIT_MAX);
        chk(rd == 8'hFF, "R5", "read timeout data", int'(rd), 255);
        tpm_xfer(1'b1, 16'h0002, 8'hC3, 9, nw, sy, bad, rd, tail, early);
        chk(sy && nw == WAIT_MAX && tail, "R5", "write timeout waits", nw, WAIT_MAX);
        tpm_xfer(1'b0, 16'h0002, 8'h00, 0, nw, sy, bad, rd, tail, early);
        chk(rd == expm[2], "R5", "timed-out write dropped", int'(rd), int'(expm[2]));

        // R6: refused write stays silent and leaves the aliased byte unchanged
        tpm_xfer(1'b1, 16'hF002, 8'h5A, 0, nw, sy, bad, rd, tail, early);
        chk(!sy && !bad && nw == 0 && !early, "R6", "refused write silent", nw, 0);
        tpm_xfer(1'b0, 16'hF002, 8'h00, 0, nw, sy, bad, rd, tail, early);
        chk(!sy && !bad && nw == 0, "R6", "refused read silent", nw, 0);
        tpm_xfer(1'b0, 16'h0002, 8'h00, 1, nw, sy, bad, rd, tail, early);
        chk(rd == expm[2], "R6", "refused write not stored", int'(rd), int'(expm[2]));

        // R1: all foreign START values, then all foreign direction nibbles
        for (int s = 0; s < 16; s++) begin
            if (s == 5) continue;
            foreign(4'(s), 4'h2, drove);
            chk(!drove, "R1", $sformatf("start %0d answered", s), int'(drove), 0);
        end
        for (int c = 0; c < 16; c++) begin
            if (c == 0 || c == 2) continue;
            foreign(4'h5, 4'(c), drove);
            chk(!drove, "R1", $sformatf("dir %0d answered", c), int'(drove), 0);
        end

        // R8: strobe abort in the header
        begin
            bit any; any = 0;
            cyc(1'b0, 4'h5, oe_s, o_s); cyc(1'b1, 4'h2, oe_s, o_s);
            cyc(1'b1, 4'h0, oe_s, o_s); cyc(1'b1, 4'h0, oe_s, o_s);
            cyc(1'b0, 4'h0, oe_s, o_s);
            for (int i = 0; i < 10; i++) begin cyc(1'b1, 4'hF, oe_s, o_s); any |= oe_s; end
            chk(!any, "R8", "header abort silent", int'(any), 0);
        end
        // R8: strobe abort during long wait drops the write
        begin
            bit any, sawwait; int c0;
            cur_lat = 3; any = 0; c0 = commits;
            cyc(1'b0, 4'h5, oe_s, o_s); cyc(1'b1, 4'h2, oe_s, o_s);
            for (int i = 0; i < 3; i++) cyc(1'b1, 4'h0, oe_s, o_s);
            cyc(1'b1, 4'h4, oe_s, o_s);
            cyc(1'b1, 4'h9, oe_s, o_s); cyc(1'b1, 4'h9, oe_s, o_s);
            cyc(1'b1, 4'hF, oe_s, o_s); cyc(1'b1, 4'hF, oe_s, o_s);
            cyc(1'b1, 4'hF, oe_s, o_s); sawwait = oe_s && o_s == 4'h6;
            cyc(1'b0, 4'h0, oe_s, o_s);
            for (int i = 0; i < 8; i++) begin cyc(1'b1, 4'hF, oe_s, o_s); any |= oe_s; end
            chk(sawwait, "R8", "wait before abort", int'(sawwait), 1);
            chk(!any && commits == c0, "R8", "wait abort silent", commits - c0, 0);
            tpm_xfer(1'b0, 16'h0004, 8'h00, 0, nw, sy, bad, rd, tail, early);
            chk(rd == expm[4], "R8", "aborted write not stored", int'(rd), int'(expm[4]));
        end
        // R8: new START mid-header restarts the cycle
        cyc(1'b0, 4'h5, oe_s, o_s); cyc(1'b1, 4'h2, oe_s, o_s); cyc(1'b1, 4'h0, oe_s, o_s);
        tpm_xfer(1'b0, 16'h000B, 8'h00, 2, nw, sy, bad, rd, tail, early);
        chk(sy && rd == expm[11] && tail, "R8", "restart read", int'(rd), int'(expm[11]));

        // R9: reset in the middle of a wait abandons the write
        begin
            int c0; c0 = commits; cur_lat = 4;
            cyc(1'b0, 4'h5, oe_s, o_s); cyc(1'b1, 4'h2, oe_s, o_s);
            for (int i = 0; i < 3; i++) cyc(1'b1, 4'h0, oe_s, o_s);
            cyc(1'b1, 4'h5, oe_s, o_s);
            cyc(1'b1, 4'hE, oe_s, o_s); cyc(1'b1, 4'hE, oe_s, o_s);
            cyc(1'b1, 4'hF, oe_s, o_s); cyc(1'b1, 4'hF, oe_s, o_s);
            cyc(1'b1, 4'hF, oe_s, o_s);
            @(negedge clk); rst_n = 1'b0;
            @(negedge clk);
            chk(!lad_oe && !reg_rd && !reg_wr, "R9", "mid-cycle reset", int'(lad_oe), 0);
            @(negedge clk); rst_n = 1'b1;
            chk(commits == c0, "R9", "no write after reset", commits - c0, 0);
            tpm_xfer(1'b0, 16'h0005, 8'h00, 0, nw, sy, bad, rd, tail, early);
            chk(sy && rd == expm[5], "R9", "byte kept after reset", int'(rd), int'(expm[5]));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule